// File: doc/BRIEF.md
# Critical-Register Access Audit Logger

This block sits beside a register bus as a passive observer and keeps a tamper-resistant record of every access made to registers that the integration has marked as critical. For each such access it stores one entry holding the identity of the requesting master, whether the access was a read or a write, the register address, and the value of a free-running timestamp counter taken in the cycle the access was seen. Accesses to registers outside the critical set leave no trace.

The log only grows. Entries are written once, in arrival order, and nothing on the observed bus can overwrite, change or remove them. Once the storage is full, later captures are discarded and a sticky overflow flag records the loss. The earlier entries stay intact, and only a reset clears the log.

Entries are read back through a dedicated audit port, one entry per request. The port keeps its own read index. Only a request that carries the designated audit role returns data and moves the index forward. A request from any other role returns zero and leaves the index where it was. Reading does not remove anything, so the entry count is unaffected.

Top module: `audit_logger`

## Requirements
- R1: A bus access to a critical address (bit `bus_addr` of parameter `CRIT_MAP` set) produces one entry packed as {id, op, addr, ts}. The timestamp sits in bits [TS_W-1:0], the address directly above it, then one op bit (1 = write, 0 = read), and the requester ID in the top ID_W bits.
- R2: An access sampled at clock edge N is written into the log at edge N+1, and `log_count` increments at that same edge N+1.
- R3: An audit request whose role differs from `AUDIT_ROLE` returns `aud_data` = 0 and `aud_ok` = 0, and it does not advance the read index.
- R4: Accesses to addresses whose `CRIT_MAP` bit is clear create no entry and leave `log_count` unchanged.
- R5: Audit-role requests return entries in the order they were written, one per request, with `aud_ok` = 1 in the cycle after the request. Reading does not change `log_count`.
- R6: When `log_count` equals `DEPTH`, further critical accesses are dropped and every stored entry keeps its value.
- R7: `log_overflow` rises when a capture is dropped and stays high until reset.
- R8: The timestamp is a free-running counter that is cleared to 0 only by reset and increments by one on every clock edge after reset. The counter wraps.
- R9: An audit-role request made when no unread entry remains returns `aud_data` = 0 and `aud_ok` = 0.
- R10: After reset, `log_count` = 0, `log_overflow` = 0, `aud_data` = 0 and `aud_ok` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | An access is present on the observed bus this cycle |
| bus_write | input | 1 | 1 = write access, 0 = read access |
| bus_id | input | ID_W | Requesting master identifier |
| bus_addr | input | ADDR_W | Register address of the access |
| aud_rd | input | 1 | Audit read request |
| aud_role | input | ROLE_W | Role of the audit requester |
| aud_data | output | EW | Returned entry, or zero when refused |
| aud_ok | output | 1 | aud_data holds a valid entry |
| log_count | output | PTR_W | Number of entries stored |
| log_overflow | output | 1 | Sticky flag: at least one capture was dropped |

## Verification
The embedded assertions check several rules on every cycle. The timestamp steps by exactly one. The write pointer only ever holds or moves forward by one, and it freezes once a capture is dropped. The overflow flag never falls. A refused request, whether from the wrong role or with no unread entry, yields zero. The read index never passes the write pointer. The assertions cannot show that stored fields match what crossed the bus, that entries come back in order with their original timestamps, or that the storage is left untouched after it fills. Only the bench scenarios show these, by comparing read-back entries against entries it packs itself from its own cycle count.

// File: rtl/audit_log_pkg.sv
package audit_log_pkg;

  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } op_e;

  // width of one packed log entry: id, op bit, address, timestamp
  function automatic int entry_width(input int id_w, input int addr_w, input int ts_w);
    return id_w + 1 + addr_w + ts_w;
  endfunction

endpackage

// File: rtl/alg_ts_counter.sv
module alg_ts_counter #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] ts_o
);

  function automatic logic [TS_W-1:0] next_ts(input logic [TS_W-1:0] cur);
    return cur + TS_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) ts_o <= '0;
    else        ts_o <= next_ts(ts_o);
  end

  // R8: counter advances by exactly one per cycle outside reset
  a_r8_ts_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ts_o == TS_W'($past(ts_o) + 1));

endmodule

// File: rtl/alg_capture.sv
module alg_capture #(
  parameter int          ID_W     = 4,
  parameter int          ADDR_W   = 6,
  parameter int          TS_W     = 16,
  parameter logic [(1<<ADDR_W)-1:0] CRIT_MAP = '0,
  localparam int         EW       = audit_log_pkg::entry_width(ID_W, ADDR_W, TS_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ID_W-1:0]   bus_id,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [TS_W-1:0]   ts,
  output logic              cap_vld,
  output logic [EW-1:0]     cap_entry
);
  import audit_log_pkg::*;

  function automatic logic is_critical(input logic [ADDR_W-1:0] a);
    return CRIT_MAP[a];
  endfunction

  function automatic logic [EW-1:0] pack_entry(input logic [ID_W-1:0] id, input op_e op,
                                               input logic [ADDR_W-1:0] a,
                                               input logic [TS_W-1:0] t);
    return {id, logic'(op), a, t};
  endfunction

  logic hit;
  op_e  op_now;

  assign hit    = bus_valid && is_critical(bus_addr);
  assign op_now = bus_write ? OP_WRITE : OP_READ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_vld   <= 1'b0;
      cap_entry <= '0;
    end else begin
      cap_vld <= hit;
      if (hit) cap_entry <= pack_entry(bus_id, op_now, bus_addr, ts);
    end
  end

  // R1: a critical access is staged in the next cycle
  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && CRIT_MAP[bus_addr]) |=> cap_vld);

  // R4: a non-critical or absent access stages nothing
  a_r4_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && CRIT_MAP[bus_addr]) |=> !cap_vld);

endmodule

// File: rtl/alg_log_store.sv
module alg_log_store #(
  parameter int  EW    = 27,
  parameter int  DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_vld,
  input  logic [EW-1:0]    cap_entry,
  input  logic [PTR_W-1:0] rd_addr,
  output logic [EW-1:0]    rd_entry,
  output logic [PTR_W-1:0] wr_ptr,
  output logic             ovf
);

  logic [EW-1:0] mem [DEPTH];
  logic          full;
  logic          wr_fire;
  logic          drop;

  function automatic logic [IDX_W-1:0] slot(input logic [PTR_W-1:0] p);
    return IDX_W'(p);
  endfunction

  assign full    = (wr_ptr == PTR_W'(DEPTH));
  assign wr_fire = cap_vld && !full;
  assign drop    = cap_vld && full;

  // storage is write-once: only the slot at wr_ptr is ever written
  always_ff @(posedge clk) begin
    if (wr_fire) mem[slot(wr_ptr)] <= cap_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      ovf    <= 1'b0;
    end else begin
      if (wr_fire) wr_ptr <= wr_ptr + PTR_W'(1);
      if (drop)    ovf    <= 1'b1;
    end
  end

  assign rd_entry = (rd_addr < PTR_W'(DEPTH)) ? mem[slot(rd_addr)] : '0;

  // R6: the write pointer never moves backward nor jumps
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (wr_ptr == $past(wr_ptr)) || (wr_ptr == $past(wr_ptr) + PTR_W'(1)));

  // R6: a dropped capture leaves the pointer where it was
  a_r6_drop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> wr_ptr == $past(wr_ptr));

  // R6: the pointer never exceeds the depth
  a_r6_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr <= PTR_W'(DEPTH));

  // R7: overflow flag is sticky
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

endmodule

// File: rtl/alg_audit_port.sv
module alg_audit_port #(
  parameter int          EW         = 27,
  parameter int          DEPTH      = 8,
  parameter int          ROLE_W     = 2,
  parameter logic [ROLE_W-1:0] AUDIT_ROLE = '1,
  localparam int         PTR_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [ROLE_W-1:0] rd_role,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [EW-1:0]     rd_entry,
  output logic [PTR_W-1:0]  rd_idx,
  output logic [EW-1:0]     rd_data,
  output logic              rd_ok
);

  logic role_ok;
  logic has_unread;
  logic grant;

  function automatic logic role_match(input logic [ROLE_W-1:0] r);
    return r == AUDIT_ROLE;
  endfunction

  assign role_ok    = role_match(rd_role);
  assign has_unread = rd_idx < wr_ptr;
  assign grant      = rd_req && role_ok && has_unread;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_idx  <= '0;
      rd_data <= '0;
      rd_ok   <= 1'b0;
    end else begin
      rd_ok   <= grant;
      rd_data <= grant ? rd_entry : '0;
      if (grant) rd_idx <= rd_idx + PTR_W'(1);
    end
  end

  // R3: a wrong-role request yields zero and no index movement
  a_r3_deny_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_role != AUDIT_ROLE) |=> (rd_data == '0) && !rd_ok && (rd_idx == $past(rd_idx)));

  // R9: nothing left to read yields zero
  a_r9_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_idx == wr_ptr) |=> (rd_data == '0) && !rd_ok);

  // R5: the read index moves by one only on an accepted request
  a_r5_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> rd_idx == $past(rd_idx));

endmodule

// File: rtl/audit_logger.sv
module audit_logger #(
  parameter int          ID_W       = 4,
  parameter int          ADDR_W     = 6,
  parameter int          TS_W       = 16,
  parameter int          DEPTH      = 8,
  parameter int          ROLE_W     = 2,
  parameter logic [ROLE_W-1:0] AUDIT_ROLE = 2'd3,
  parameter logic [(1<<ADDR_W)-1:0] CRIT_MAP = 64'hF000_0F00_00F0_000F,
  localparam int         EW         = audit_log_pkg::entry_width(ID_W, ADDR_W, TS_W),
  localparam int         PTR_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ID_W-1:0]   bus_id,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              aud_rd,
  input  logic [ROLE_W-1:0] aud_role,
  output logic [EW-1:0]     aud_data,
  output logic              aud_ok,
  output logic [PTR_W-1:0]  log_count,
  output logic              log_overflow
);

  logic [TS_W-1:0]  ts_now;
  logic             cap_vld;
  logic [EW-1:0]    cap_entry;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_idx;
  logic [EW-1:0]    rd_entry;

  alg_ts_counter #(.TS_W(TS_W)) u_ts (
    .clk(clk), .rst_n(rst_n), .ts_o(ts_now)
  );

  alg_capture #(.ID_W(ID_W), .ADDR_W(ADDR_W), .TS_W(TS_W), .CRIT_MAP(CRIT_MAP)) u_cap (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_id(bus_id), .bus_addr(bus_addr), .ts(ts_now),
    .cap_vld(cap_vld), .cap_entry(cap_entry)
  );

  alg_log_store #(.EW(EW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .cap_vld(cap_vld), .cap_entry(cap_entry),
    .rd_addr(rd_idx), .rd_entry(rd_entry), .wr_ptr(wr_ptr), .ovf(log_overflow)
  );

  alg_audit_port #(.EW(EW), .DEPTH(DEPTH), .ROLE_W(ROLE_W), .AUDIT_ROLE(AUDIT_ROLE)) u_port (
    .clk(clk), .rst_n(rst_n), .rd_req(aud_rd), .rd_role(aud_role),
    .wr_ptr(wr_ptr), .rd_entry(rd_entry),
    .rd_idx(rd_idx), .rd_data(aud_data), .rd_ok(aud_ok)
  );

  assign log_count = wr_ptr;

  // R5: the reader never runs ahead of the writer
  a_r5_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idx <= wr_ptr);

  // R2: a staged capture with room left raises the count on the next edge
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_vld && wr_ptr != PTR_W'(DEPTH)) |=> log_count == $past(log_count) + PTR_W'(1));

endmodule

// File: tb/audit_logger_test.sv
`timescale 1ns/1ps
module audit_logger_test;
  localparam int ID_W = 4, ADDR_W = 6, TS_W = 16, DEPTH = 8, ROLE_W = 2;
  localparam logic [ROLE_W-1:0] AUD = 2'd3;
  localparam logic [63:0] CRIT = 64'hF000_0F00_00F0_000F;
  localparam int EW = ID_W + 1 + ADDR_W + TS_W;
  localparam int PTR_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [ID_W-1:0] bus_id = '0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic aud_rd = 1'b0;
  logic [ROLE_W-1:0] aud_role = '0;
  logic [EW-1:0] aud_data;
  logic aud_ok;
  logic [PTR_W-1:0] log_count;
  logic log_overflow;

  always #2 clk = ~clk;

  audit_logger #(.ID_W(ID_W), .ADDR_W(ADDR_W), .TS_W(TS_W), .DEPTH(DEPTH),
                 .ROLE_W(ROLE_W), .AUDIT_ROLE(AUD), .CRIT_MAP(CRIT)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_id(bus_id), .bus_addr(bus_addr), .aud_rd(aud_rd), .aud_role(aud_role),
    .aud_data(aud_data), .aud_ok(aud_ok), .log_count(log_count), .log_overflow(log_overflow)
  );

  // independent cycle count: cleared in reset, +1 per edge afterwards
  logic [TS_W-1:0] bcnt = '0;
  always @(posedge clk) bcnt <= rst_n ? bcnt + 1'b1 : '0;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [EW-1:0] expq [0:15];
  int exp_n = 0;
  int clist [0:63];
  int cn = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [EW-1:0] mk(input int id, input int wr, input int a, input logic [TS_W-1:0] t);
    logic [63:0] v;
    v = (64'(id) << (1 + ADDR_W + TS_W)) + (64'(wr) << (ADDR_W + TS_W)) + (64'(a) << TS_W) + 64'(t);
    return EW'(v);
  endfunction

  // drive one access for one cycle; returns at the negedge after the sampling edge
  task automatic access(input int id, input int wr, input int a);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr[0]; bus_id = ID_W'(id); bus_addr = ADDR_W'(a);
    if (CRIT[a] && exp_n < DEPTH) begin
      expq[exp_n] = mk(id, wr, a, bcnt);
      exp_n++;
    end
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic aread(input logic [ROLE_W-1:0] r, output logic [EW-1:0] d, output logic ok);
    @(negedge clk);
    aud_rd = 1'b1; aud_role = r;
    @(negedge clk);
    aud_rd = 1'b0;
    d = aud_data; ok = aud_ok;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_n = 0;
  endtask

  initial begin
    logic [EW-1:0] d;
    logic ok;
    for (int a = 0; a < 64; a++) if (CRIT[a]) begin clist[cn] = a; cn++; end

    do_reset();
    // R10 reset state
    check(log_count == 0, "R10 count", 64'(log_count), 0);
    check(log_overflow == 0, "R10 overflow", 64'(log_overflow), 0);
    check(aud_data == 0 && aud_ok == 0, "R10 read port", 64'(aud_data), 0);

    // R4: sweep every non-critical address, both ops
    for (int a = 0; a < 64; a++) if (!CRIT[a]) access(a % 16, a % 2, a);
    @(negedge clk);
    check(log_count == 0, "R4 non-critical count", 64'(log_count), 0);
    // R9: empty log, audit role
    aread(AUD, d, ok);
    check(d == 0 && ok == 0, "R9 empty read", 64'(d), 0);

    // R1/R2: five critical accesses
    for (int k = 0; k < 5; k++) begin
      access(k + 1, k % 2, clist[k]);
      check(log_count == PTR_W'(k), "R2 not yet written", 64'(log_count), 64'(k));
      @(negedge clk);
      check(log_count == PTR_W'(k + 1), "R2 written next edge", 64'(log_count), 64'(k + 1));
    end

    // R3: every non-audit role is refused
    for (int r = 0; r < 3; r++) begin
      aread(ROLE_W'(r), d, ok);
      check(d == 0 && ok == 0, "R3 wrong role zero", 64'(d), 0);
    end
    // R5/R1/R8: first two entries in order
    for (int k = 0; k < 2; k++) begin
      aread(AUD, d, ok);
      check(ok == 1 && d == expq[k], "R5 R1 R8 entry", 64'(d), 64'(expq[k]));
    end
    check(log_count == 5, "R5 read keeps count", 64'(log_count), 5);
    aread(2'd1, d, ok);
    check(d == 0 && ok == 0, "R3 refused mid-log", 64'(d), 0);
    aread(AUD, d, ok);
    check(ok == 1 && d == expq[2], "R3 index not advanced", 64'(d), 64'(expq[2]));

    // fill to depth, then overflow
    for (int k = 5; k < 8; k++) access(k + 1, 1, clist[k]);
    @(negedge clk);
    check(log_count == DEPTH, "R6 full count", 64'(log_count), DEPTH);
    check(log_overflow == 0, "R7 no overflow at exactly full", 64'(log_overflow), 0);
    for (int k = 8; k < 12; k++) access(9, 0, clist[k]);
    @(negedge clk);
    check(log_count == DEPTH, "R6 dropped count", 64'(log_count), DEPTH);
    check(log_overflow == 1, "R7 overflow set", 64'(log_overflow), 1);
    access(2, 1, 4);
    repeat (5) @(negedge clk);
    check(log_overflow == 1, "R7 overflow sticky", 64'(log_overflow), 1);

    // R6: remaining entries intact
    for (int k = 3; k < 8; k++) begin
      aread(AUD, d, ok);
      check(ok == 1 && d == expq[k], "R6 entry intact", 64'(d), 64'(expq[k]));
    end
    aread(AUD, d, ok);
    check(d == 0 && ok == 0, "R9 all read", 64'(d), 0);

    // R8/R7/R10: reset clears flag, count and timestamp
    repeat (20) @(negedge clk);
    do_reset();
    check(log_overflow == 0, "R7 cleared by reset", 64'(log_overflow), 0);
    check(log_count == 0, "R10 count after reset", 64'(log_count), 0);
    access(15, 1, clist[cn - 1]);
    repeat (7) @(negedge clk);
    access(0, 0, clist[0]);
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      aread(AUD, d, ok);
      check(ok == 1 && d == expq[k], "R8 timestamp after reset", 64'(d), 64'(expq[k]));
    end

    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule